// File: doc/BRIEF.md
# Early-Exit Self-Test Completion Sequencer

This block runs a self-test as three ordered phases: it launches the test, polls for completion, then captures the result. A fixed delay sized for the slowest possible run would waste time on every faster one. Instead, the controller samples a completion flag once per controller cycle. It leaves the wait phase on the first sample that shows completion. A programmable maximum poll count bounds the wait. Size that count as (deterministic + non-deterministic core cycles) multiplied by (longest core period / shortest controller period), rounded up. If the count runs out first, the sequence ends in a timeout and the captured value is treated as invalid.

The self-test runs in a core clock domain that is independent of the controller clock. A core-side stub stands in for the test engine. It sees the launch request through a synchronizer and forces the status flag to "in progress". It holds that value for a programmable number of core cycles, then raises the flag to "done". The status flag does not have a pin of its own. It shares an existing output pin, which carries a functional signal whenever no test is selected. The flag returns to the controller through a two-flop synchronizer. The multi-bit result is captured only after the synchronized "done" has been seen.

Controller states:
- IDLE: waiting for a start request.
- LOAD: launch asserted for a fixed number of cycles.
- WAIT: polling the flag.
- READ: result capture.
- RELEASE: launch dropped; waits for the flag to clear.

Transitions:
- IDLE→LOAD on start.
- LOAD→WAIT after LOAD_CYCLES cycles.
- WAIT→READ on a synchronized "done".
- WAIT→RELEASE on reaching the poll limit, which is the timeout.
- READ→RELEASE after one cycle.
- RELEASE→IDLE once REL_CYCLES cycles have passed and the synchronized flag is low.

Top module: `bist_wait_seq`

## Requirements
- R1: After reset, `busy`, `result_valid` and `timeout` are 0, `result` and `wait_cycles` are 0, and `shared_pin` follows `func_in`.
- R2: A `start` seen in IDLE at a controller edge makes `busy` read 1 after that same edge; `busy` never rises without `start` at the previous edge.
- R3: Once the launch has reached the core domain, the core forces the status flag to 0 ("in progress"). `shared_pin` then shows 0 until the run finishes, whatever `func_in` does.
- R4: The core raises the status flag to 1 ("done") max(`core_run_len`,1) core cycles after the launch is detected, and `shared_pin` shows that 1 while the test is still selected.
- R5: While no test is selected (the synchronized launch is low), `shared_pin` equals `func_in`.
- R6: WAIT takes one sample of the synchronized flag per controller cycle. The first sample reading 1 moves to READ at the next edge. `wait_cycles` reports the number of samples taken, including that one, and `result_valid` rises two cycles after that sample's flag value.
- R7: If the sample count reaches `max_loop` (a value of 0 counts as 1) without a 1, then `timeout`=1, `result_valid`=0 and `wait_cycles` equals that limit.
- R8: On success, `result_valid`=1 and `result` holds the value `result_core` had at the READ edge.
- R9: `start` is ignored while `busy` is 1.
- R10: After readout or timeout, the launch is dropped, `busy` stays 1 for at least REL_CYCLES cycles until the synchronized flag is low, and `shared_pin` then reverts to `func_in`.
- R11: `result_valid` and `timeout` are never both 1. All result outputs hold while idle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Controller clock |
| ctl_rst_n | input | 1 | Controller active-low reset |
| core_clk | input | 1 | Core clock, independent of ctl_clk |
| core_rst_n | input | 1 | Core active-low reset |
| start | input | 1 | Start request, controller domain |
| max_loop | input | 32 | Maximum number of poll samples |
| core_run_len | input | RUNW | Stub run length in core cycles |
| result_core | input | W | Self-test result, core domain |
| func_in | input | 1 | Functional signal sharing the pin |
| shared_pin | output | 1 | Pin carrying the status flag or the functional signal |
| busy | output | 1 | Sequence in progress |
| result_valid | output | 1 | Result captured after completion |
| timeout | output | 1 | Poll limit reached without completion |
| result | output | W | Captured result |
| wait_cycles | output | 32 | Poll samples actually used |

## Verification
`busy` is due after the very controller edge that takes `start`, so the bench checks it at the next falling edge. The end of a run cannot be placed on an exact cycle, because the clocks are unrelated. The bench therefore waits for `busy` to fall, and only then reads `result`, `result_valid`, `timeout` and `wait_cycles`, which are registered earlier and held. `wait_cycles` is checked against a window. The window is computed from the run length, the two periods, the two synchronizer depths and the LOAD length. Timeout runs choose `max_loop` below the window's lower end, so that their count is exact. Pin checks are made several controller cycles after each change, which leaves room for the launch synchronizer.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_WAIT    = 3'd2,
        ST_READ    = 3'd3,
        ST_RELEASE = 3'd4
    } seq_state_t;

endpackage

// File: rtl/bist_sync.sv
module bist_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bist_core_stub.sv
module bist_core_stub #(
    parameter int RUNW        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            core_clk,
    input  logic            core_rst_n,
    input  logic            launch,
    input  logic [RUNW-1:0] run_len,
    input  logic            func_in,
    output logic            status_flag,
    output logic            pin_out
);
    localparam logic [RUNW-1:0] LAST = RUNW'(1);

    logic            launch_s;
    logic            launch_d;
    logic            running_q;
    logic [RUNW-1:0] cnt_q;
    logic            flag_q;
    logic            launch_rise;

    bist_sync #(.STAGES(SYNC_STAGES)) u_launch_sync (
        .clk   (core_clk),
        .rst_n (core_rst_n),
        .d     (launch),
        .q     (launch_s)
    );

    assign launch_rise = launch_s & ~launch_d;

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            launch_d  <= 1'b0;
            running_q <= 1'b0;
            cnt_q     <= '0;
            flag_q    <= 1'b0;
        end else begin
            launch_d <= launch_s;
            if (!launch_s) begin
                running_q <= 1'b0;
                cnt_q     <= '0;
                flag_q    <= 1'b0;
            end else if (launch_rise) begin
                // precondition: flag forced to "in progress"
                running_q <= 1'b1;
                cnt_q     <= run_len;
                flag_q    <= 1'b0;
            end else if (running_q) begin
                if (cnt_q <= LAST) begin
                    flag_q    <= 1'b1;
                    running_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign status_flag = flag_q;
    // pin sharing: status flag only while a test is selected
    assign pin_out     = launch_s ? flag_q : func_in;
endmodule

// File: rtl/bist_wait_fsm.sv
module bist_wait_fsm
    import bist_seq_pkg::*;
#(
    parameter int W           = 16,
    parameter int LOAD_CYCLES = 4,
    parameter int REL_CYCLES  = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [31:0]  max_loop,
    input  logic         done_s,
    input  logic [W-1:0] result_core,
    output logic         launch,
    output logic         busy,
    output logic         result_valid,
    output logic         timeout,
    output logic [W-1:0] result,
    output logic [31:0]  wait_cycles
);
    localparam int              PHW       = $clog2(LOAD_CYCLES + REL_CYCLES + 1) + 1;
    localparam logic [PHW-1:0]  LOAD_LAST = PHW'(LOAD_CYCLES - 1);
    localparam logic [PHW-1:0]  REL_LAST  = PHW'(REL_CYCLES - 1);

    seq_state_t     state_q, state_d;
    logic [PHW-1:0] ph_cnt_q;
    logic [31:0]    poll_q;
    logic [32:0]    poll_next;
    logic [32:0]    loop_lim;
    logic           at_limit;

    assign poll_next = {1'b0, poll_q} + 33'd1;
    assign loop_lim  = (max_loop == 32'd0) ? 33'd1 : {1'b0, max_loop};
    assign at_limit  = (poll_next >= loop_lim);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_LOAD;
            ST_LOAD:    if (ph_cnt_q == LOAD_LAST) state_d = ST_WAIT;
            ST_WAIT: begin
                if (done_s)        state_d = ST_READ;
                else if (at_limit) state_d = ST_RELEASE;
            end
            ST_READ:    state_d = ST_RELEASE;
            ST_RELEASE: if (ph_cnt_q >= REL_LAST && !done_s) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt_q     <= '0;
            poll_q       <= '0;
            launch       <= 1'b0;
            busy         <= 1'b0;
            result_valid <= 1'b0;
            timeout      <= 1'b0;
            result       <= '0;
            wait_cycles  <= '0;
        end else begin
            busy   <= (state_d != ST_IDLE);
            launch <= (state_d == ST_LOAD) || (state_d == ST_WAIT) || (state_d == ST_READ);

            if (state_d != state_q)  ph_cnt_q <= '0;
            else if (ph_cnt_q != '1) ph_cnt_q <= ph_cnt_q + 1'b1;

            if (state_q == ST_WAIT) poll_q <= poll_next[31:0];
            else                    poll_q <= '0;

            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        result_valid <= 1'b0;
                        timeout      <= 1'b0;
                        result       <= '0;
                        wait_cycles  <= '0;
                    end
                end
                ST_WAIT: begin
                    if (done_s) begin
                        wait_cycles <= poll_next[31:0];
                    end else if (at_limit) begin
                        wait_cycles <= poll_next[31:0];
                        timeout     <= 1'b1;
                    end
                end
                ST_READ: begin
                    result       <= result_core;
                    result_valid <= 1'b1;
                end
                ST_LOAD, ST_RELEASE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bist_wait_seq.sv
module bist_wait_seq #(
    parameter int W           = 16,
    parameter int RUNW        = 16,
    parameter int LOAD_CYCLES = 4,
    parameter int REL_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            ctl_clk,
    input  logic            ctl_rst_n,
    input  logic            core_clk,
    input  logic            core_rst_n,
    input  logic            start,
    input  logic [31:0]     max_loop,
    input  logic [RUNW-1:0] core_run_len,
    input  logic [W-1:0]    result_core,
    input  logic            func_in,
    output logic            shared_pin,
    output logic            busy,
    output logic            result_valid,
    output logic            timeout,
    output logic [W-1:0]    result,
    output logic [31:0]     wait_cycles
);
    logic launch;
    logic status_flag;
    logic done_ctl;

    bist_core_stub #(.RUNW(RUNW), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .core_clk    (core_clk),
        .core_rst_n  (core_rst_n),
        .launch      (launch),
        .run_len     (core_run_len),
        .func_in     (func_in),
        .status_flag (status_flag),
        .pin_out     (shared_pin)
    );

    bist_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk   (ctl_clk),
        .rst_n (ctl_rst_n),
        .d     (status_flag),
        .q     (done_ctl)
    );

    bist_wait_fsm #(.W(W), .LOAD_CYCLES(LOAD_CYCLES), .REL_CYCLES(REL_CYCLES)) u_fsm (
        .clk          (ctl_clk),
        .rst_n        (ctl_rst_n),
        .start        (start),
        .max_loop     (max_loop),
        .done_s       (done_ctl),
        .result_core  (result_core),
        .launch       (launch),
        .busy         (busy),
        .result_valid (result_valid),
        .timeout      (timeout),
        .result       (result),
        .wait_cycles  (wait_cycles)
    );
endmodule

// File: rtl/bist_wait_seq_chk.sv
module bist_wait_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic [31:0]  max_loop,
    input logic [W-1:0] result_core,
    input logic         done_s,
    input logic         result_valid,
    input logic         timeout,
    input logic [W-1:0] result,
    input logic [31:0]  wait_cycles
);
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(result_valid && timeout));

    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_timeout_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (wait_cycles == ((max_loop == 32'd0) ? 32'd1 : max_loop)));

    assert_exit_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $past(done_s, 2));

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> (result == $past(result_core)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result_valid) && $stable(timeout) &&
                               $stable(wait_cycles) && $stable(result)));
endmodule

bind bist_wait_seq bist_wait_seq_chk #(.W(W)) u_chk (
    .clk          (ctl_clk),
    .rst_n        (ctl_rst_n),
    .start        (start),
    .busy         (busy),
    .max_loop     (max_loop),
    .result_core  (result_core),
    .done_s       (done_ctl),
    .result_valid (result_valid),
    .timeout      (timeout),
    .result       (result),
    .wait_cycles  (wait_cycles)
);

// File: tb/bist_wait_seq_test.sv
module bist_wait_seq_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W     = 16;
    localparam int RUNW  = 16;
    localparam int LOADC = 4;
    localparam int RELC  = 8;

    logic            ctl_clk = 1'b0;
    logic            core_clk = 1'b0;
    logic            ctl_rst_n, core_rst_n;
    logic            start;
    logic [31:0]     max_loop;
    logic [RUNW-1:0] core_run_len;
    logic [W-1:0]    result_core;
    logic            func_in;
    logic            shared_pin, busy, result_valid, timeout;
    logic [W-1:0]    result;
    logic [31:0]     wait_cycles;

    int total = 0;
    int bad   = 0;

    always #5   ctl_clk  = ~ctl_clk;
    always #3.5 core_clk = ~core_clk;

    bist_wait_seq #(.W(W), .RUNW(RUNW), .LOAD_CYCLES(LOADC), .REL_CYCLES(RELC)) uut (
        .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
        .start(start), .max_loop(max_loop), .core_run_len(core_run_len),
        .result_core(result_core), .func_in(func_in), .shared_pin(shared_pin),
        .busy(busy), .result_valid(result_valid), .timeout(timeout),
        .result(result), .wait_cycles(wait_cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // window of poll samples: core 7 ns, controller 10 ns, two-flop syncs
    function automatic int win_lo(input int n);
        int ne = (n < 1) ? 1 : n;
        int v  = ((ne + 2) * 7) / 10 + 1 - LOADC;
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int win_hi(input int n);
        int ne = (n < 1) ? 1 : n;
        int v  = ((ne + 3) * 7 + 9) / 10 + 3 - LOADC;
        return (v < 1) ? 1 : v;
    endfunction

    task automatic run_one(input int n, input int ml, input logic [W-1:0] rv,
                           input bit expect_to, input bit poke_start, input bit pre_chk);
        int   cyc;
        bit   saw_one;
        logic [31:0]  wc_keep;
        logic [W-1:0] res_keep;
        @(negedge ctl_clk);
        core_run_len = RUNW'(n);
        max_loop     = ml;
        result_core  = rv;
        func_in      = 1'b0;
        start        = 1'b1;
        @(negedge ctl_clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        saw_one = 1'b0;
        cyc = 1;
        while (busy && cyc < 20000) begin
            if (shared_pin && !func_in) saw_one = 1'b1;
            if (pre_chk && cyc == 8)
                chk(shared_pin == 1'b0, "R3", "pin in progress", shared_pin, 0);
            if (pre_chk && cyc == 5) func_in = 1'b1;
            if (pre_chk && cyc == 10) func_in = 1'b0;
            start = (poke_start && cyc == 10);
            @(negedge ctl_clk);
            cyc++;
        end
        start   = 1'b0;
        func_in = 1'b0;
        chk(!busy, "R10", "sequence ended", busy, 0);
        if (expect_to) begin
            chk(timeout == 1'b1, "R7", "timeout flag", timeout, 1);
            chk(result_valid == 1'b0, "R7", "no valid on timeout", result_valid, 0);
            chk(wait_cycles == ((ml == 0) ? 1 : ml), "R7", "timeout count",
                wait_cycles, (ml == 0) ? 1 : ml);
        end else begin
            chk(result_valid == 1'b1, "R8", "valid", result_valid, 1);
            chk(result == rv, "R8", "result value", result, rv);
            chk(timeout == 1'b0, "R11", "no timeout", timeout, 0);
            chk(int'(wait_cycles) >= win_lo(n) && int'(wait_cycles) <= win_hi(n),
                "R6", "wait_cycles window", wait_cycles, win_lo(n));
            chk(saw_one, "R4", "done seen on pin", saw_one, 1);
        end
        repeat (3) @(negedge ctl_clk);
        func_in = 1'b1;
        @(negedge ctl_clk);
        chk(shared_pin == 1'b1, "R5", "pin follows func high", shared_pin, 1);
        func_in = 1'b0;
        @(negedge ctl_clk);
        chk(shared_pin == 1'b0, "R5", "pin follows func low", shared_pin, 0);
        wc_keep  = wait_cycles;
        res_keep = result;
        result_core = ~rv;
        repeat (4) @(negedge ctl_clk);
        chk(wait_cycles == wc_keep && result == res_keep, "R11", "outputs held",
            wait_cycles, wc_keep);
        if (poke_start)
            chk(busy == 1'b0, "R9", "no relaunch from ignored start", busy, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge ctl_clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        ctl_rst_n = 1'b0; core_rst_n = 1'b0;
        start = 1'b0; max_loop = 32'd0; core_run_len = '0;
        result_core = '0; func_in = 1'b0;
        repeat (5) @(negedge ctl_clk);
        ctl_rst_n = 1'b1; core_rst_n = 1'b1;
        @(negedge ctl_clk);
        chk(busy == 1'b0, "R1", "busy reset", busy, 0);
        chk(result_valid == 1'b0 && timeout == 1'b0, "R1", "flags reset",
            {result_valid, timeout}, 0);
        chk(result == '0 && wait_cycles == 32'd0, "R1", "result reset", wait_cycles, 0);
        func_in = 1'b1;
        @(negedge ctl_clk);
        chk(shared_pin == 1'b1, "R1", "pin follows func after reset", shared_pin, 1);
        func_in = 1'b0;

        run_one(100, 2000, 16'hA5C3, 1'b0, 1'b1, 1'b1);  // R9 ignored start, R3
        run_one(150, 0,    16'h1234, 1'b1, 1'b0, 1'b0);  // R7 zero limit acts as one
        run_one(0,   500,  16'hBEEF, 1'b0, 1'b0, 1'b0);  // shortest run
        run_one(200, 3,    16'h0F0F, 1'b1, 1'b0, 1'b1);  // R7 small limit
        run_one(1,   5000, 16'hFFFF, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 30; i++) begin
            int n  = int'($urandom % 200);
            int lo = win_lo(n);
            int hi = win_hi(n);
            logic [W-1:0] rv = W'($urandom);
            if (($urandom % 4) == 0 && lo >= 2)
                run_one(n, int'($urandom % lo), rv, 1'b1, 1'b0, 1'b0);
            else
                run_one(n, hi + int'($urandom % 100), rv, 1'b0, 1'b0, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule